// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Threshold Requests

This block is the receive half of an asynchronous serial port. It brings a free-running serial input into the clock domain, waits for a qualified start edge, and times each bit with an oversampling counter so that every data bit is sampled near its centre. Characters are 8 data bits, least significant bit first, followed by one stop bit. Each good character is written into a small receive queue, and the consumer reads it from a show-ahead data port.

A fill-level comparator asserts a receive-data flag while the queue holds more characters than a programmable trigger level. That flag, gated by two separate enables, drives an interrupt request and a DMA request. The requests are levels and drop by themselves once reads drain the queue to the trigger level. A receive-disable input stops new characters from being accepted. A character that finds the queue full is dropped, and a sticky overrun bit records the loss.

Top module: `uart_rx_fifo_req`

## Requirements
- R1: After reset `fifo_count` is 0, `fifo_empty` is 1, and `rx_data_flag`, `irq_req`, `dma_req` and `overrun` are all 0.
- R2: While `rx_disable` is 1, no start bit is recognised, and a complete frame on `rxd` adds nothing to the queue.
- R3: A start bit needs `rxd` to be seen high and then low while reception is enabled. If `rxd` is already low when `rx_disable` falls to 0, that low level starts no character.
- R4: A bit lasts OVERSAMPLE*TICK_DIV clocks. Data bits are sampled at mid-bit, least significant bit first, and 8 data bits are followed by a high stop bit. Each good character is appended to the queue.
- R5: If `rxd` is high again at the middle of the start bit, the start is treated as a glitch and no character is produced.
- R6: A character whose stop bit samples low is discarded.
- R7: `rd_data` shows the oldest character. A one-cycle `rd_en` pulse removes it. `rd_en` on an empty queue leaves `fifo_count` at 0.
- R8: The queue holds DEPTH characters. A character that arrives while the queue is full is discarded, the stored contents are unchanged, and `overrun` goes to 1.
- R9: `overrun` stays 1 until `ovr_clr` is pulsed, which returns it to 0.
- R10: `rx_data_flag` is 1 exactly when `fifo_count` is greater than `trig_level`. It falls by itself once reads bring the count down to the trigger level.
- R11: `irq_req` is 1 when `rx_data_flag` is 1 and `irq_en` is 1, and is 0 otherwise.
- R12: `dma_req` is 1 when `rx_data_flag` is 1 and `dma_en` is 1, and is 0 otherwise.
- R13: Raising `rx_disable` in the middle of a character does not abort it. The character completes and is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rx_disable | input | 1 | 1 blocks recognition of new start bits |
| trig_level | input | $clog2(DEPTH) | Fill level that must be exceeded to raise the flag |
| irq_en | input | 1 | Enables the interrupt request |
| dma_en | input | 1 | Enables the DMA request |
| rd_en | input | 1 | Pop strobe for the oldest character |
| rd_data | output | DATA_BITS | Oldest stored character (show-ahead) |
| fifo_count | output | $clog2(DEPTH+1) | Characters held in the queue |
| fifo_empty | output | 1 | Queue holds nothing |
| ovr_clr | input | 1 | Write-one pulse that clears `overrun` |
| overrun | output | 1 | Sticky: a character was lost to a full queue |
| rx_data_flag | output | 1 | Fill level is above the trigger level |
| irq_req | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the block with OVERSAMPLE=16, TICK_DIV=1, DEPTH=16 and 8 data bits. With these values a bit lasts 16 clocks and a whole frame about 170. Filling the queue to its full depth and forcing an overrun, together with the glitch, bad-stop, enable-while-low and mid-frame-disable cases, therefore stays within a few thousand cycles. The 4-bit trigger reaches its extremes 0 and 15, so the flag can be checked both at its first step and at a full queue.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2,
        FR_STOP  = 2'd3
    } frm_state_e;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int TICK_DIV   = 8,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd_s,
    input  logic                 rx_disable,
    output logic                 chr_valid,
    output logic [DATA_BITS-1:0] chr_data,
    output logic                 busy
);
    localparam int BIT_CYC = OVERSAMPLE * TICK_DIV;
    localparam int HALF    = BIT_CYC / 2;
    localparam int CW      = $clog2(BIT_CYC + 1);
    localparam int BW      = $clog2(DATA_BITS + 1);

    typedef struct packed {
        frm_state_e           state;
        logic [CW-1:0]        cnt;
        logic [BW-1:0]        bitn;
        logic [DATA_BITS-1:0] shreg;
        logic [DATA_BITS-1:0] data;
        logic                 armed;
        logic                 push;
    } frm_t;

    frm_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.push = 1'b0;
        unique case (r_q.state)
            FR_IDLE: begin
                r_d.cnt  = '0;
                r_d.bitn = '0;
                if (rx_disable) begin
                    r_d.armed = 1'b0;
                end else if (rxd_s) begin
                    r_d.armed = 1'b1;
                end else if (r_q.armed) begin
                    r_d.armed = 1'b0;
                    r_d.state = FR_START;
                end
            end
            FR_START: begin
                if (r_q.cnt == CW'(HALF - 1)) begin
                    r_d.cnt   = '0;
                    r_d.state = rxd_s ? FR_IDLE : FR_DATA;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            FR_DATA: begin
                if (r_q.cnt == CW'(BIT_CYC - 1)) begin
                    r_d.cnt   = '0;
                    r_d.shreg = {rxd_s, r_q.shreg[DATA_BITS-1:1]};
                    r_d.bitn  = r_q.bitn + BW'(1);
                    if (r_q.bitn == BW'(DATA_BITS - 1)) r_d.state = FR_STOP;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            FR_STOP: begin
                if (r_q.cnt == CW'(BIT_CYC - 1)) begin
                    r_d.cnt   = '0;
                    r_d.state = FR_IDLE;
                    if (rxd_s) begin
                        r_d.push = 1'b1;
                        r_d.data = r_q.shreg;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            default: r_d.state = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= FR_IDLE;
            r_q.cnt   <= '0;
            r_q.bitn  <= '0;
            r_q.shreg <= '0;
            r_q.data  <= '0;
            r_q.armed <= 1'b0;
            r_q.push  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign chr_valid = r_q.push;
    assign chr_data  = r_q.data;
    assign busy      = (r_q.state != FR_IDLE);
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop,
    input  logic                       ovr_clr,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       overrun
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0]   wptr;
        logic [AW-1:0]   rptr;
        logic [CNTW-1:0] count;
        logic            ovr;
    } fifo_t;

    fifo_t f_d, f_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_pop, do_push, is_full;

    always_comb begin
        f_d     = f_q;
        is_full = (f_q.count == CNTW'(DEPTH));
        do_pop  = pop && (f_q.count != '0);
        do_push = push && (!is_full || do_pop);

        if (do_push)
            f_d.wptr = (f_q.wptr == AW'(DEPTH - 1)) ? '0 : f_q.wptr + AW'(1);
        if (do_pop)
            f_d.rptr = (f_q.rptr == AW'(DEPTH - 1)) ? '0 : f_q.rptr + AW'(1);

        unique case ({do_push, do_pop})
            2'b10:   f_d.count = f_q.count + CNTW'(1);
            2'b01:   f_d.count = f_q.count - CNTW'(1);
            default: f_d.count = f_q.count;
        endcase

        if (push && !do_push) f_d.ovr = 1'b1;
        else if (ovr_clr)     f_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.wptr  <= '0;
            f_q.rptr  <= '0;
            f_q.count <= '0;
            f_q.ovr   <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[f_q.wptr] <= push_data;
    end

    assign head    = mem[f_q.rptr];
    assign count   = f_q.count;
    assign empty   = (f_q.count == '0);
    assign overrun = f_q.ovr;
endmodule

// File: rtl/uart_rx_fifo_req.sv
module uart_rx_fifo_req #(
    parameter int OVERSAMPLE  = 16,
    parameter int TICK_DIV    = 8,
    parameter int DATA_BITS   = 8,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int TRGW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd,
    input  logic                 rx_disable,
    input  logic [TRGW-1:0]      trig_level,
    input  logic                 irq_en,
    input  logic                 dma_en,
    input  logic                 rd_en,
    output logic [DATA_BITS-1:0] rd_data,
    output logic [CNTW-1:0]      fifo_count,
    output logic                 fifo_empty,
    input  logic                 ovr_clr,
    output logic                 overrun,
    output logic                 rx_data_flag,
    output logic                 irq_req,
    output logic                 dma_req
);
    typedef struct packed {
        logic flag;
        logic irq;
        logic dma;
    } req_t;

    logic                 rxd_s;
    logic                 chr_valid;
    logic [DATA_BITS-1:0] chr_data;
    logic                 frm_busy;
    req_t                 req_d, req_q;

    rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rxd_s)
    );

    rx_framer #(
        .OVERSAMPLE (OVERSAMPLE),
        .TICK_DIV   (TICK_DIV),
        .DATA_BITS  (DATA_BITS)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd_s      (rxd_s),
        .rx_disable (rx_disable),
        .chr_valid  (chr_valid),
        .chr_data   (chr_data),
        .busy       (frm_busy)
    );

    rx_fifo #(.WIDTH(DATA_BITS), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (chr_valid),
        .push_data (chr_data),
        .pop       (rd_en),
        .ovr_clr   (ovr_clr),
        .head      (rd_data),
        .count     (fifo_count),
        .empty     (fifo_empty),
        .overrun   (overrun)
    );

    always_comb begin
        req_d.flag = (fifo_count > CNTW'(trig_level));
        req_d.irq  = req_d.flag && irq_en;
        req_d.dma  = req_d.flag && dma_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign rx_data_flag = req_q.flag;
    assign irq_req      = req_q.irq;
    assign dma_req      = req_q.dma;
endmodule

// File: rtl/uart_rx_fifo_req_chk.sv
module uart_rx_fifo_req_chk #(
    parameter int DEPTH = 16,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rx_disable,
    input logic            rd_en,
    input logic            ovr_clr,
    input logic [CNTW-1:0] fifo_count,
    input logic            overrun,
    input logic            rx_data_flag,
    input logic            irq_req,
    input logic            dma_req,
    input logic            chr_valid,
    input logic            frm_busy
);
    localparam logic [CNTW:0] ONE  = (CNTW+1)'(1);
    localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_disable && !frm_busy) |=> !frm_busy); // R2

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == '0 && !chr_valid) |=> (fifo_count == '0)); // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (({1'b0, fifo_count} <= ({1'b0, $past(fifo_count)} + ONE)) &&
                  (({1'b0, fifo_count} + ONE) >= {1'b0, $past(fifo_count)}))); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= FULL); // R8

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && fifo_count == FULL && !rd_en) |=> (fifo_count == FULL && overrun)); // R8

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun); // R9

    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && fifo_count != FULL) |=> !overrun); // R9

    AST_FLAG_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == '0 && $past(fifo_count) == '0) |-> !rx_data_flag); // R10

    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ($past(fifo_count) != '0)); // R11

    AST_DMA_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> ($past(fifo_count) != '0)); // R12
endmodule

bind uart_rx_fifo_req uart_rx_fifo_req_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_disable   (rx_disable),
    .rd_en        (rd_en),
    .ovr_clr      (ovr_clr),
    .fifo_count   (fifo_count),
    .overrun      (overrun),
    .rx_data_flag (rx_data_flag),
    .irq_req      (irq_req),
    .dma_req      (dma_req),
    .chr_valid    (chr_valid),
    .frm_busy     (frm_busy)
);

// File: tb/tb_uart_rx_fifo_req.sv
module tb_uart_rx_fifo_req;
    localparam int OVS   = 16;
    localparam int TDIV  = 1;
    localparam int DEPTH = 16;
    localparam int BIT   = OVS * TDIV;
    localparam int TRGW  = $clog2(DEPTH);
    localparam int CNTW  = $clog2(DEPTH + 1);
    localparam int NVEC  = 6;
    localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h5A};
    localparam int VTRIG = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic rx_disable = 1'b0;
    logic [TRGW-1:0] trig_level = '0;
    logic irq_en = 1'b0;
    logic dma_en = 1'b0;
    logic rd_en = 1'b0;
    logic ovr_clr = 1'b0;
    logic [7:0] rd_data;
    logic [CNTW-1:0] fifo_count;
    logic fifo_empty, overrun, rx_data_flag, irq_req, dma_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_rx_fifo_req #(
        .OVERSAMPLE(OVS), .TICK_DIV(TDIV), .DATA_BITS(8), .DEPTH(DEPTH), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_disable(rx_disable),
        .trig_level(trig_level), .irq_en(irq_en), .dma_en(dma_en),
        .rd_en(rd_en), .rd_data(rd_data), .fifo_count(fifo_count),
        .fifo_empty(fifo_empty), .ovr_clr(ovr_clr), .overrun(overrun),
        .rx_data_flag(rx_data_flag), .irq_req(irq_req), .dma_req(dma_req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drives one frame; dis_bit >= 0 raises rx_disable at that data bit.
    task automatic send_frame(input logic [7:0] d, input logic stopv, input int dis_bit);
        rxd = 1'b0;
        tick(BIT);
        for (int b = 0; b < 8; b++) begin
            if (b == dis_bit) rx_disable = 1'b1;
            rxd = d[b];
            tick(BIT);
        end
        rxd = stopv;
        tick(BIT);
        rxd = 1'b1;
        tick(6);
    endtask

    task automatic pop_check(input logic [7:0] exp, input string req);
        check_eq(req, "rd_data", rd_data, exp);
        rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(5);
        // R1 reset state
        check_eq("R1", "count in reset", fifo_count, 0);
        rst_n = 1'b1;
        tick(6);
        check_eq("R1", "count", fifo_count, 0);
        check_eq("R1", "empty", fifo_empty, 1);
        check_eq("R1", "flag", rx_data_flag, 0);
        check_eq("R1", "irq", irq_req, 0);
        check_eq("R1", "dma", dma_req, 0);
        check_eq("R1", "overrun", overrun, 0);

        // Table walk: R4 framing, R10/R11/R12 requests
        trig_level = TRGW'(VTRIG);
        irq_en = 1'b1;
        dma_en = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            send_frame(VEC[i], 1'b1, -1);
            check_eq("R4", "count after frame", fifo_count, i + 1);
            check_eq("R10", "flag vs trigger", rx_data_flag, int'(i + 1 > VTRIG));
            check_eq("R11", "irq with enable", irq_req, int'(i + 1 > VTRIG));
            check_eq("R12", "dma disabled", dma_req, 0);
        end
        for (int i = 0; i < NVEC; i++) begin
            pop_check(VEC[i], "R7");
            check_eq("R7", "count after pop", fifo_count, NVEC - 1 - i);
            check_eq("R10", "flag after pop", rx_data_flag, int'(NVEC - 1 - i > VTRIG));
        end

        // R7 pop on empty
        rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
        tick(2);
        check_eq("R7", "count after empty pop", fifo_count, 0);
        check_eq("R7", "empty after empty pop", fifo_empty, 1);

        // R12 / R11 with trigger 0
        trig_level = '0;
        irq_en = 1'b0;
        dma_en = 1'b1;
        send_frame(8'hC3, 1'b1, -1);
        check_eq("R10", "flag trig 0", rx_data_flag, 1);
        check_eq("R12", "dma enabled", dma_req, 1);
        check_eq("R11", "irq disabled", irq_req, 0);
        pop_check(8'hC3, "R4");
        check_eq("R12", "dma after drain", dma_req, 0);
        dma_en = 1'b0;

        // R2 disabled frame
        rx_disable = 1'b1;
        tick(4);
        send_frame(8'h3C, 1'b1, -1);
        check_eq("R2", "count while disabled", fifo_count, 0);
        rx_disable = 1'b0;
        tick(6);

        // R3 line low at enable
        rx_disable = 1'b1;
        rxd = 1'b0;
        tick(20);
        rx_disable = 1'b0;
        tick(BIT * 9);
        rxd = 1'b1;
        tick(BIT * 2);
        check_eq("R3", "count after low enable", fifo_count, 0);
        send_frame(8'h96, 1'b1, -1);
        check_eq("R3", "count after real edge", fifo_count, 1);
        pop_check(8'h96, "R3");

        // R5 start glitch
        rxd = 1'b0;
        tick(4);
        rxd = 1'b1;
        tick(BIT * 11);
        check_eq("R5", "count after glitch", fifo_count, 0);

        // R6 bad stop bit
        send_frame(8'h55, 1'b0, -1);
        tick(BIT);
        check_eq("R6", "count after bad stop", fifo_count, 0);

        // R13 disable during a character
        send_frame(8'h6B, 1'b1, 2);
        check_eq("R13", "count after mid disable", fifo_count, 1);
        rx_disable = 1'b0;
        tick(6);
        pop_check(8'h6B, "R13");

        // R8 / R9 fill and overrun
        trig_level = TRGW'(DEPTH - 1);
        for (int i = 0; i < DEPTH; i++) begin
            send_frame(8'((i * 17) + 3), 1'b1, -1);
            if (i == DEPTH - 2) check_eq("R10", "flag at trig", rx_data_flag, 0);
        end
        check_eq("R8", "count full", fifo_count, DEPTH);
        check_eq("R10", "flag above max trig", rx_data_flag, 1);
        check_eq("R8", "no overrun yet", overrun, 0);
        send_frame(8'hEE, 1'b1, -1);
        check_eq("R8", "count after overflow", fifo_count, DEPTH);
        check_eq("R8", "overrun set", overrun, 1);
        check_eq("R8", "head unchanged", rd_data, 3);
        tick(50);
        check_eq("R9", "overrun sticky", overrun, 1);
        ovr_clr = 1'b1;
        tick(1);
        ovr_clr = 1'b0;
        tick(2);
        check_eq("R9", "overrun cleared", overrun, 0);
        for (int i = 0; i < DEPTH; i++) begin
            pop_check(8'((i * 17) + 3), "R8");
        end
        check_eq("R8", "drained, dropped char absent", fifo_count, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule